// File: doc/BRIEF.md
# Four-to-One Packet Concentrator

This block merges four processor injection links onto a single router injection channel that carries one 50-bit phit per clock. Each processor link has its own small phit queue and a full flag that tells the processor to stop sending. A round-robin arbiter picks which link owns the output. The winning link keeps the output until its whole packet has gone out. Packets have a fixed length of `PKT_PHITS` phits: one header followed by body phits.

When a link's queue is empty and the output is free, an arriving header is granted in the cycle it arrives. It goes straight to the output register without being stored, so it leaves one clock later. When a link already has phits queued, new phits join the back of the queue, and a grant always serves the oldest queued phit. As each header leaves, the router-node part of its destination is rewritten from absolute to relative form against the local node identifier.

Top module: `pkt_concentrator`

## Requirements
- R1: The phit layout is as follows. Bits 49:48 are a credit field, bit 47 is valid and bit 46 is head. In a header, bits 45:36 are the destination and bits 35:0 are data; in a body phit, bits 45:0 are data. The credit field and the data bits are passed to the output unchanged.
- R2: An input phit whose valid bit 47 is clear is ignored. It is neither stored nor sent, whatever its other bits hold.
- R3: A header that arrives at a link with an empty queue while the output is free appears on `inj_phit` on the next clock edge.
- R4: After a packet from link w finishes, arbitration searches for a requesting link starting at link w+1 and wrapping around. Only a link whose oldest phit is a header can request.
- R5: Once granted, a link owns the output until it has sent exactly `PKT_PHITS` phits: its header and then its own body phits in order. No phit from another link is interleaved.
- R6: The phits of each link leave in the order they arrived, whether they were queued or passed straight through.
- R7: `src_full[p]` is high exactly when link p's queue holds `FIFO_DEPTH-1` or more phits. A queue never holds more than `FIFO_DEPTH` phits.
- R8: In each outgoing header, destination bits [9:2] are four 2-bit digits. Relative digit i equals destination digit i minus `node_id[2i+1:2i]`, modulo 4. Destination bits [1:0] are copied unchanged.
- R9: When another packet is waiting, its header follows the previous packet's last phit on the very next cycle, with no idle phit between them.
- R10: During reset and on the first cycle after it, `inj_phit` is all zeros and every full flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 8 | Local router node identifier, four 2-bit digits |
| src_phit | input | 4x50 | One phit per processor link per cycle |
| src_full | output | 4 | Per-link queue nearly full |
| inj_phit | output | 50 | Registered phit to the router injection channel |

## Verification
The assertions assume that every link sends well-formed packets: a header followed by exactly `PKT_PHITS-1` body phits. They also assume that a processor sends nothing in a cycle when its full flag is high. The no-overflow property relies on that second assumption. The stimulus builds each packet from one generator that emits a header and then the right number of body phits. Its per-link driver checks `src_full` before it offers a valid phit, and otherwise drives an invalid junk phit.

// File: rtl/conc_pkg.sv
package conc_pkg;
  localparam int PHIT_W   = 50;
  localparam int CRED_HI  = 49;
  localparam int CRED_LO  = 48;
  localparam int VLD_BIT  = 47;
  localparam int HEAD_BIT = 46;
  localparam int DEST_HI  = 45;
  localparam int DEST_LO  = 36;
  localparam int DEST_W   = DEST_HI - DEST_LO + 1;
  localparam int NODE_W   = DEST_W - 2;
  typedef logic [PHIT_W-1:0] phit_t;
endpackage

// File: rtl/conc_fifo.sv
module conc_fifo #(
  parameter int W     = 50,
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= (int'(wp) == DEPTH-1) ? '0 : wp + AW'(1);
      if (rd_en) rp <= (int'(rp) == DEPTH-1) ? '0 : rp + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rp];
  assign empty   = (count == '0);
endmodule

// File: rtl/conc_rr_arb.sv
module conc_rr_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  input  logic [IW-1:0] adv_idx,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int off = 0; off < N; off++) begin
      int cand;
      cand = (int'(ptr) + off) % N;
      if (!gnt_any && req[cand]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (adv)
      ptr <= (int'(adv_idx) == N-1) ? '0 : adv_idx + IW'(1);
  end
endmodule

// File: rtl/conc_addr_xlate.sv
module conc_addr_xlate #(
  parameter int DIGITS = 4
) (
  input  logic [2*DIGITS+1:0] abs_dest,
  input  logic [2*DIGITS-1:0] node_id,
  output logic [2*DIGITS+1:0] rel_dest
);
  assign rel_dest[1:0] = abs_dest[1:0];

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign rel_dest[2*d+3:2*d+2] = abs_dest[2*d+3:2*d+2] - node_id[2*d+1:2*d];
  end
endmodule

// File: rtl/pkt_concentrator.sv
module pkt_concentrator
  import conc_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int PKT_PHITS  = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NODE_W-1:0]              node_id,
  input  logic [NPORTS-1:0][PHIT_W-1:0]  src_phit,
  output logic [NPORTS-1:0]              src_full,
  output logic [PHIT_W-1:0]              inj_phit
);
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int LW = $clog2(PKT_PHITS + 1);

  logic [NPORTS-1:0]         in_vld, fifo_empty, push, pop, req, send_oh, front_ok;
  logic [NPORTS-1:0][CW-1:0] fifo_cnt;
  phit_t                     fifo_front [NPORTS];
  phit_t                     front      [NPORTS];

  logic          locked, send, pkt_done, gnt_any;
  logic [IW-1:0] owner, gnt_idx, sel_idx;
  logic [LW-1:0] sent_cnt;
  phit_t         sel_phit;
  logic [DEST_W-1:0] rel_dest;

  // taps for the bound checker
  logic       out_vld, out_head, sel_head;
  logic [1:0] out_dlo, sel_dlo;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign in_vld[p] = src_phit[p][VLD_BIT];

    conc_fifo #(.W(PHIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (push[p]),
      .wr_data (src_phit[p]),
      .rd_en   (pop[p]),
      .rd_data (fifo_front[p]),
      .empty   (fifo_empty[p]),
      .count   (fifo_cnt[p])
    );

    // oldest phit of the link: queue head, else the phit arriving now
    assign front[p]    = fifo_empty[p] ? phit_t'(src_phit[p]) : fifo_front[p];
    assign front_ok[p] = fifo_empty[p] ? in_vld[p] : 1'b1;
    assign req[p]      = !locked && front_ok[p] && front[p][HEAD_BIT];
    assign send_oh[p]  = send && (sel_idx == IW'(p));
    assign pop[p]      = send_oh[p] && !fifo_empty[p];
    // a phit that leaves in its arrival cycle is never written
    assign push[p]     = in_vld[p] && !(send_oh[p] && fifo_empty[p]);
    assign src_full[p] = (fifo_cnt[p] >= CW'(FIFO_DEPTH - 1));
  end

  conc_rr_arb #(.N(NPORTS), .IW(IW)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .adv     (pkt_done),
    .adv_idx (sel_idx),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  always_comb begin
    sel_idx  = locked ? owner : gnt_idx;
    send     = locked ? front_ok[owner] : gnt_any;
    sel_phit = front[sel_idx];
    if (locked)
      pkt_done = send && (sent_cnt == LW'(PKT_PHITS - 1));
    else
      pkt_done = send && (PKT_PHITS == 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      owner    <= '0;
      sent_cnt <= '0;
    end else if (send) begin
      if (pkt_done) begin
        locked   <= 1'b0;
        sent_cnt <= '0;
      end else begin
        locked   <= 1'b1;
        owner    <= sel_idx;
        sent_cnt <= sent_cnt + LW'(1);
      end
    end
  end

  conc_addr_xlate #(.DIGITS(NODE_W / 2)) u_xlate (
    .abs_dest (sel_phit[DEST_HI:DEST_LO]),
    .node_id  (node_id),
    .rel_dest (rel_dest)
  );

  always_ff @(posedge clk) begin
    if (rst)
      inj_phit <= '0;
    else if (send && sel_phit[HEAD_BIT])
      inj_phit <= {sel_phit[PHIT_W-1:DEST_HI+1], rel_dest, sel_phit[DEST_LO-1:0]};
    else if (send)
      inj_phit <= sel_phit;
    else
      inj_phit <= '0;
  end

  assign out_vld  = inj_phit[VLD_BIT];
  assign out_head = inj_phit[HEAD_BIT];
  assign out_dlo  = inj_phit[DEST_LO+1:DEST_LO];
  assign sel_head = sel_phit[HEAD_BIT];
  assign sel_dlo  = sel_phit[DEST_LO+1:DEST_LO];
endmodule

// File: rtl/pkt_concentrator_chk.sv
module pkt_concentrator_chk #(
  parameter int NPORTS     = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int PKT_PHITS  = 3,
  parameter int CW         = 4,
  parameter int IW         = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NPORTS-1:0]         in_vld,
  input logic [NPORTS-1:0][CW-1:0] fifo_cnt,
  input logic                      out_vld,
  input logic                      out_head,
  input logic [1:0]                out_dlo,
  input logic                      send,
  input logic                      sel_head,
  input logic [1:0]                sel_dlo,
  input logic                      locked,
  input logic [IW-1:0]             owner,
  input logic                      pkt_done
);
  localparam int PW = $clog2(PKT_PHITS + 1);
  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (out_vld)
      pos <= (pos == PW'(PKT_PHITS - 1)) ? '0 : pos + PW'(1);
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) fifo_cnt[p] <= CW'(FIFO_DEPTH)); // R7
    AST_IGNORE_INVALID: assert property (@(posedge clk) disable iff (rst) !in_vld[p] |=> fifo_cnt[p] <= $past(fifo_cnt[p])); // R2
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !out_vld); // R10
  AST_HEAD_STARTS_PKT: assert property (@(posedge clk) disable iff (rst) (out_vld && out_head) |-> pos == '0); // R5
  AST_BODY_IN_PKT: assert property (@(posedge clk) disable iff (rst) (out_vld && !out_head) |-> pos != '0); // R5
  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (rst) (locked && !pkt_done) |=> (locked && owner == $past(owner))); // R5
  AST_LOW_DEST_KEPT: assert property (@(posedge clk) disable iff (rst) (send && sel_head) |=> out_dlo == $past(sel_dlo)); // R8
endmodule

bind pkt_concentrator pkt_concentrator_chk #(
  .NPORTS(NPORTS), .FIFO_DEPTH(FIFO_DEPTH), .PKT_PHITS(PKT_PHITS), .CW(CW), .IW(IW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .fifo_cnt (fifo_cnt),
  .out_vld  (out_vld),
  .out_head (out_head),
  .out_dlo  (out_dlo),
  .send     (send),
  .sel_head (sel_head),
  .sel_dlo  (sel_dlo),
  .locked   (locked),
  .owner    (owner),
  .pkt_done (pkt_done)
);

// File: tb/pkt_concentrator_test.sv
module pkt_concentrator_test;
  localparam int NP = 4;
  localparam int DEPTH = 8;
  localparam int PKT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] node_id = 8'hE4;
  logic [NP-1:0][49:0] src_phit;
  logic [NP-1:0] src_full;
  logic [49:0] inj_phit;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int drv_cnt [NP], out_cnt [NP], exp_pkt [NP], nxt_pkt [NP], first_drv [NP];
  int ord_port [256], ord_cyc [256];
  int n_ord = 0, total_out = 0, cur_port = -1, cur_pos = 0;
  bit saw_full = 1'b0;

  pkt_concentrator #(.NPORTS(NP), .FIFO_DEPTH(DEPTH), .PKT_PHITS(PKT)) uut (
    .clk(clk), .rst(rst), .node_id(node_id),
    .src_phit(src_phit), .src_full(src_full), .inj_phit(inj_phit)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  localparam logic [49:0] JUNK = {2'b11, 1'b0, 1'b1, 46'h1555_5555_5555};

  function automatic logic [9:0] dest_of(int p, int k);
    return 10'((k * 37 + p * 101 + 5) % 1024);
  endfunction

  function automatic logic [9:0] rel_of(logic [9:0] d, logic [7:0] n);
    logic [9:0] r;
    r[1:0] = d[1:0];
    for (int i = 0; i < 4; i++) r[2+2*i +: 2] = d[2+2*i +: 2] - n[2*i +: 2];
    return r;
  endfunction

  function automatic logic [49:0] mk(int p, int pkt, int pos);
    logic [11:0] tag;
    tag = {8'(pkt), 2'(p), 2'(pos)};
    if (pos == 0) return {2'b01, 1'b1, 1'b1, dest_of(p, pkt), 24'h0, tag};
    return {2'b10, 1'b1, 1'b0, 34'h0, tag};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // output monitor, mid-cycle after each rising edge
  always begin
    @(posedge clk);
    #5;
    if (!rst) begin
      if (inj_phit[47]) begin
        int p, pos, pkt;
        p = int'(inj_phit[3:2]);
        pos = int'(inj_phit[1:0]);
        pkt = int'(inj_phit[11:4]);
        out_cnt[p]++;
        total_out++;
        if (inj_phit[46]) begin
          check(cur_pos == 0, "R5", "header inside packet", 64'(cur_pos), 64'(0));
          check(pkt == exp_pkt[p] % 256, "R6", "packet order", 64'(pkt), 64'(exp_pkt[p]));
          check(inj_phit[45:36] == rel_of(dest_of(p, pkt), node_id), "R8", "relative dest",
                64'(inj_phit[45:36]), 64'(rel_of(dest_of(p, pkt), node_id)));
          check(inj_phit[49:48] == 2'b01 && pos == 0, "R1", "header credit/tag",
                64'(inj_phit[49:48]), 64'(1));
          ord_port[n_ord] = p;
          ord_cyc[n_ord] = cyc;
          n_ord++;
          exp_pkt[p]++;
          cur_port = p;
          cur_pos = (PKT == 1) ? 0 : 1;
        end else begin
          check(cur_pos != 0 && p == cur_port && pos == cur_pos, "R5", "body sequence",
                64'(p * 16 + pos), 64'(cur_port * 16 + cur_pos));
          check(inj_phit[49:48] == 2'b10, "R1", "body credit", 64'(inj_phit[49:48]), 64'(2));
          cur_pos = (cur_pos + 1) % PKT;
        end
      end
      for (int p = 0; p < NP; p++) begin
        bit ef;
        ef = (drv_cnt[p] - out_cnt[p]) >= DEPTH - 1;
        check(src_full[p] == ef, "R7", "full flag", 64'(src_full[p]), 64'(ef));
        if (src_full[p]) saw_full = 1'b1;
      end
    end
  end

  task automatic run_stream(input int n0, input int n1, input int n2, input int n3);
    int npk [NP];
    int idx [NP];
    int tgt;
    bit done;
    npk[0] = n0; npk[1] = n1; npk[2] = n2; npk[3] = n3;
    tgt = total_out;
    for (int p = 0; p < NP; p++) begin
      idx[p] = 0;
      first_drv[p] = -1;
      tgt += npk[p] * PKT;
    end
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      done = 1'b1;
      for (int p = 0; p < NP; p++) begin
        if (idx[p] < npk[p] * PKT && !src_full[p]) begin
          src_phit[p] = mk(p, nxt_pkt[p] + idx[p] / PKT, idx[p] % PKT);
          if (idx[p] == 0) first_drv[p] = cyc;
          drv_cnt[p]++;
          idx[p]++;
        end else begin
          src_phit[p] = JUNK;
        end
        if (idx[p] < npk[p] * PKT) done = 1'b0;
      end
    end
    @(negedge clk);
    for (int p = 0; p < NP; p++) src_phit[p] = JUNK;
    for (int w = 0; w < 200 && total_out != tgt; w++) @(negedge clk);
    check(total_out == tgt, "R6", "all phits delivered", 64'(total_out), 64'(tgt));
    for (int p = 0; p < NP; p++) nxt_pkt[p] += npk[p];
  endtask

  task automatic test_reset();
    check(inj_phit == '0, "R10", "output after reset", 64'(inj_phit[47:0]), 64'(0));
    check(src_full == '0, "R10", "full after reset", 64'(src_full), 64'(0));
  endtask

  task automatic test_bypass();
    int b;
    b = n_ord;
    run_stream(0, 1, 0, 0);
    check(ord_port[b] == 1, "R3", "bypass port", 64'(ord_port[b]), 64'(1));
    check(ord_cyc[b] == first_drv[1] + 1, "R3", "bypass latency", 64'(ord_cyc[b]), 64'(first_drv[1] + 1));
  endtask

  task automatic test_rr();
    int b;
    int exp_o [4];
    b = n_ord;
    exp_o[0] = 2; exp_o[1] = 3; exp_o[2] = 0; exp_o[3] = 1;
    run_stream(1, 1, 1, 1);
    check(ord_cyc[b] == first_drv[2] + 1, "R3", "same-cycle grant under contention",
          64'(ord_cyc[b]), 64'(first_drv[2] + 1));
    for (int i = 0; i < 4; i++)
      check(ord_port[b+i] == exp_o[i], "R4", "rotation order", 64'(ord_port[b+i]), 64'(exp_o[i]));
    for (int i = 0; i < 3; i++)
      check(ord_cyc[b+i+1] - ord_cyc[b+i] == PKT, "R9", "back-to-back spacing",
            64'(ord_cyc[b+i+1] - ord_cyc[b+i]), 64'(PKT));
  endtask

  task automatic test_fifo_order();
    int b;
    int exp_o [4];
    b = n_ord;
    exp_o[0] = 3; exp_o[1] = 0; exp_o[2] = 3; exp_o[3] = 0;
    run_stream(2, 0, 0, 2);
    for (int i = 0; i < 4; i++)
      check(ord_port[b+i] == exp_o[i], "R6", "queued order", 64'(ord_port[b+i]), 64'(exp_o[i]));
    check(ord_cyc[b+3] - ord_cyc[b] == 3 * PKT, "R9", "no idle phits", 64'(ord_cyc[b+3] - ord_cyc[b]), 64'(3 * PKT));
  endtask

  task automatic test_full();
    saw_full = 1'b0;
    run_stream(4, 4, 4, 4);
    check(saw_full, "R7", "full flag raised under load", 64'(saw_full), 64'(1));
  endtask

  task automatic test_invalid();
    int b, bo;
    b = total_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) src_phit[p] = JUNK ^ {4'b0, 46'(i * 3 + p)};
    end
    repeat (3) @(negedge clk);
    check(total_out == b, "R2", "invalid phits not sent", 64'(total_out), 64'(b));
    check(src_full == '0, "R2", "no full after invalid", 64'(src_full), 64'(0));
    bo = n_ord;
    run_stream(1, 0, 0, 0);
    check(ord_cyc[bo] == first_drv[0] + 1, "R2", "queue stayed empty",
          64'(ord_cyc[bo]), 64'(first_drv[0] + 1));
  endtask

  task automatic test_node();
    @(negedge clk);
    node_id = 8'h1B;
    run_stream(1, 1, 1, 1);
    @(negedge clk);
    node_id = 8'hFF;
    run_stream(0, 0, 2, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected completion", cyc);
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      src_phit[p] = JUNK;
      drv_cnt[p] = 0; out_cnt[p] = 0; exp_pkt[p] = 0; nxt_pkt[p] = 0; first_drv[p] = -1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_bypass();
    test_rr();
    test_fifo_order();
    test_full();
    test_invalid();
    test_node();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule